// File: doc/BRIEF.md
# Transmit/Receive Byte Queues with Threshold Flags for a Two-Wire Master

This block sits between a processor register port and the byte engine of a two-wire (I2C) bus master. It holds two independent byte queues of 16 entries each: one that software fills and the engine drains (transmit), and one that the engine fills and software drains (receive). A single data register serves both directions. Writing it appends to the transmit queue and reading it removes the oldest receive byte.

Software sets a fill threshold for each queue. The block raises sticky status flags when the receive queue has collected enough bytes, when the transmit queue has drained down to its threshold, and when the engine reports that the final byte has left an empty transmit queue. Each flag has an enable bit, and the enabled flags are combined into one interrupt line. Software can empty either queue on its own through the control register. Both occupancy counts can be read back.

Register addresses on `reg_addr`: 0 data, 1 control, 2 status, 3 interrupt enable, 4 receive count, 5 transmit count. Any other address reads as zero.

Top module: `i2c_fifo_trig`

## Requirements
- R1: Each queue holds at most 16 bytes. A data-register write while the transmit queue is full is dropped. An engine push while the receive queue is full is dropped. A pop from an empty queue is dropped. `eng_tx_avail` is high when the transmit queue is not empty, and `eng_rx_space` is high when the receive queue is not full.
- R2: Bytes leave each queue in the order they entered. `eng_tx_data` shows the oldest transmit byte, or 0 when that queue is empty. A read of address 0 shows the oldest receive byte, or 0 when empty, and a read strobe there removes that byte.
- R3: Control bit 0 written as 1 empties the transmit queue. Control bit 1 written as 1 empties the receive queue. Each takes effect at the next clock edge, leaves the other queue untouched, and wins over a push or pop in the same cycle. Both bits read back as 0.
- R4: The receive threshold sits in control bits 7:4. Status bit 1 is set one cycle after the receive count is at least that field plus one.
- R5: The transmit threshold code sits in control bits 3:2. Codes 0, 1, 2 and 3 select levels of 8, 4, 2 and 0 bytes remaining. Status bit 0 is set one cycle after the transmit count is at or below the selected level.
- R6: Status bit 2 is set one cycle after `eng_tx_done` is high while the transmit queue is empty.
- R7: Status bits are sticky. A write to address 2 clears each bit written as 0 and keeps each bit written as 1. A set condition in the same cycle wins over the clear.
- R8: The interrupt-enable register at address 3 holds bits 2:0, laid out like the status bits. `irq` is high whenever some status bit and its enable bit are both 1.
- R9: Address 4 reads the receive count and address 5 reads the transmit count, each from 0 to 16.
- R10: After reset, both queues are empty and the control, status and enable registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (removes a receive byte at address 0) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the current address |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_avail | output | 1 | Transmit queue not empty |
| eng_tx_done | input | 1 | Engine finished shifting out a byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_space | output | 1 | Receive queue not full |
| irq | output | 1 | Interrupt request |

## Verification
Because the flags are sticky, the transmit-threshold flag is already set a cycle after reset, when the transmit queue is empty. A drain that crosses the threshold only means something if software first fills the queue above the level and then clears the status. The stimulus therefore loads 16 bytes, clears the status by writing zeros, and only then lets the engine pop. It repeats this for each threshold code, so the flag's rising cycle can be seen. Clearing a flag whose set condition is still true is exercised by writing zero to the status while the transmit queue is empty, so the flag must stay set. Full-queue pushes that coincide with a pop are also driven, so the dropped push and the accepted pop happen in the same cycle.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int NFLAG  = 3;

    localparam logic [ADDR_W-1:0] ADDR_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_IEN   = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_RXCNT = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_TXCNT = 3'd5;

    localparam int CTL_TXCLR = 0;
    localparam int CTL_RXCLR = 1;

    localparam int FLG_TXLVL = 0;
    localparam int FLG_RXLVL = 1;
    localparam int FLG_TEND  = 2;

    typedef struct packed {
        logic [3:0] rx_trig;
        logic [1:0] tx_code;
    } trig_cfg_t;

    function automatic int unsigned tx_level(input logic [1:0] code, input int unsigned depth);
        case (code)
            2'd0:    return depth / 2;
            2'd1:    return depth / 4;
            2'd2:    return depth / 8;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/i2cf_fifo.sv
module i2cf_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t d, q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (q.cnt == '0);
    assign full    = (q.cnt == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (do_push) d.wp = nxt(q.wp);
            if (do_pop)  d.rp = nxt(q.rp);
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + CW'(1);
                2'b01:   d.cnt = q.cnt - CW'(1);
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= din;
    end

    assign dout  = empty ? '0 : mem[q.rp];
    assign count = q.cnt;

endmodule

// File: rtl/i2cf_regs.sv
module i2cf_regs
    import i2cf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CW-1:0]     tx_cnt,
    input  logic [CW-1:0]     rx_cnt,
    input  logic              tx_done,
    output logic              flush_tx,
    output logic              flush_rx,
    output trig_cfg_t         cfg,
    output logic [NFLAG-1:0]  stat,
    output logic [NFLAG-1:0]  ien,
    output logic              irq
);

    typedef struct packed {
        trig_cfg_t        cfg;
        logic [NFLAG-1:0] stat;
        logic [NFLAG-1:0] ien;
    } reg_t;

    reg_t d, q;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] kept;
    logic wr_ctrl, wr_stat, wr_ien;

    assign wr_ctrl = wr && (addr == ADDR_CTRL);
    assign wr_stat = wr && (addr == ADDR_STAT);
    assign wr_ien  = wr && (addr == ADDR_IEN);

    always_comb begin
        set_vec            = '0;
        set_vec[FLG_TXLVL] = (tx_cnt <= CW'(tx_level(q.cfg.tx_code, DEPTH)));
        set_vec[FLG_RXLVL] = (int'(rx_cnt) >= int'(q.cfg.rx_trig) + 1);
        set_vec[FLG_TEND]  = tx_done && (tx_cnt == '0);

        kept = wr_stat ? (q.stat & wdata[NFLAG-1:0]) : q.stat;

        d      = q;
        d.stat = kept | set_vec;
        if (wr_ctrl) begin
            d.cfg.rx_trig = wdata[7:4];
            d.cfg.tx_code = wdata[3:2];
        end
        if (wr_ien) d.ien = wdata[NFLAG-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flush_tx = wr_ctrl && wdata[CTL_TXCLR];
    assign flush_rx = wr_ctrl && wdata[CTL_RXCLR];
    assign cfg      = q.cfg;
    assign stat     = q.stat;
    assign ien      = q.ien;
    assign irq      = |(q.stat & q.ien);

endmodule

// File: rtl/i2c_fifo_trig.sv
module i2c_fifo_trig
    import i2cf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_data,
    output logic              eng_tx_avail,
    input  logic              eng_tx_done,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic              eng_rx_space,
    output logic              irq
);

    logic              flush_tx, flush_rx;
    logic              tx_push, rx_pop;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [DATA_W-1:0] rx_head;
    trig_cfg_t         cfg_w;
    logic [NFLAG-1:0]  stat_w, ien_w;
    logic [3:0]        rx_trig_w;

    assign tx_push   = reg_wr && (reg_addr == ADDR_DATA);
    assign rx_pop    = reg_rd && (reg_addr == ADDR_DATA);
    assign rx_trig_w = cfg_w.rx_trig;

    i2cf_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush_tx),
        .push  (tx_push),
        .din   (reg_wdata),
        .pop   (eng_tx_pop),
        .dout  (eng_tx_data),
        .count (tx_cnt),
        .empty (tx_empty),
        .full  (tx_full)
    );

    i2cf_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush_rx),
        .push  (eng_rx_push),
        .din   (eng_rx_data),
        .pop   (rx_pop),
        .dout  (rx_head),
        .count (rx_cnt),
        .empty (rx_empty),
        .full  (rx_full)
    );

    i2cf_regs #(.DEPTH(DEPTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .tx_cnt   (tx_cnt),
        .rx_cnt   (rx_cnt),
        .tx_done  (eng_tx_done),
        .flush_tx (flush_tx),
        .flush_rx (flush_rx),
        .cfg      (cfg_w),
        .stat     (stat_w),
        .ien      (ien_w),
        .irq      (irq)
    );

    assign eng_tx_avail = !tx_empty;
    assign eng_rx_space = !rx_full;

    always_comb begin
        case (reg_addr)
            ADDR_DATA:  reg_rdata = rx_head;
            ADDR_CTRL:  reg_rdata = {cfg_w.rx_trig, cfg_w.tx_code, 2'b00};
            ADDR_STAT:  reg_rdata = DATA_W'(stat_w);
            ADDR_IEN:   reg_rdata = DATA_W'(ien_w);
            ADDR_RXCNT: reg_rdata = DATA_W'(rx_cnt);
            ADDR_TXCNT: reg_rdata = DATA_W'(tx_cnt);
            default:    reg_rdata = '0;
        endcase
    end

    logic unused_ok;
    assign unused_ok = &{1'b0, tx_full, rx_empty};

endmodule

// File: rtl/i2cf_chk.sv
module i2cf_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [2:0]    reg_addr,
    input logic [7:0]    reg_wdata,
    input logic          eng_rx_push,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic [2:0]    stat,
    input logic [2:0]    ien,
    input logic [3:0]    rx_trig,
    input logic          irq
);

    AST_TX_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CW'(DEPTH)); // R1

    AST_RX_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == CW'(DEPTH)) && eng_rx_push && !(reg_rd && reg_addr == 3'd0)
        && !(reg_wr && reg_addr == 3'd1 && reg_wdata[1])
        |=> rx_cnt == CW'(DEPTH)); // R1

    AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && (reg_addr == 3'd1) && reg_wdata[0] |=> tx_cnt == '0); // R3

    AST_RX_TRIG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rx_cnt) >= int'(rx_trig) + 1) |=> stat[1]); // R4

    AST_STAT_KEEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && (reg_addr == 3'd2) && stat[2] && reg_wdata[2] |=> stat[2]); // R7

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 3'b000) |-> !irq); // R8

endmodule

bind i2c_fifo_trig i2cf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .eng_rx_push (eng_rx_push),
    .tx_cnt      (tx_cnt),
    .rx_cnt      (rx_cnt),
    .stat        (stat_w),
    .ien         (ien_w),
    .rx_trig     (rx_trig_w),
    .irq         (irq)
);

// File: tb/test_i2c_fifo_trig.sv
module test_i2c_fifo_trig;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       eng_tx_pop = 1'b0, eng_tx_done = 1'b0, eng_rx_push = 1'b0;
    logic [7:0] eng_rx_data = 8'd0;
    logic [7:0] eng_tx_data;
    logic       eng_tx_avail, eng_rx_space, irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    byte unsigned txq[$];
    byte unsigned rxq[$];
    int unsigned m_rxt, m_txc, m_stat, m_ien, setv, otx, orx;

    always #4 clk = ~clk;

    i2c_fifo_trig i_i2c_fifo_trig (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_tx_avail(eng_tx_avail), .eng_tx_done(eng_tx_done),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_rx_space(eng_rx_space), .irq(irq)
    );

    function automatic int unsigned lvl(input int unsigned c);
        case (c)
            0: return 8;
            1: return 4;
            2: return 2;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Behavioural model, advanced on every rising edge, then compared 2 ns later.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_rxt = 0; m_txc = 0; m_stat = 0; m_ien = 0;
        end else begin
            otx = txq.size();
            orx = rxq.size();
            setv = 0;
            if (otx <= lvl(m_txc))            setv |= 1; // R5
            if (orx >= m_rxt + 1)             setv |= 2; // R4
            if (eng_tx_done && otx == 0)      setv |= 4; // R6
            if (reg_wr && reg_addr == 1 && reg_wdata[0]) txq.delete();
            else begin
                if (eng_tx_pop && otx > 0) void'(txq.pop_front());
                if (reg_wr && reg_addr == 0 && otx < 16) txq.push_back(reg_wdata);
            end
            if (reg_wr && reg_addr == 1 && reg_wdata[1]) rxq.delete();
            else begin
                if (reg_rd && reg_addr == 0 && orx > 0) void'(rxq.pop_front());
                if (eng_rx_push && orx < 16) rxq.push_back(eng_rx_data);
            end
            if (reg_wr && reg_addr == 2) m_stat = m_stat & reg_wdata[2:0];
            m_stat |= setv;
            if (reg_wr && reg_addr == 1) begin
                m_rxt = reg_wdata[7:4];
                m_txc = reg_wdata[3:2];
            end
            if (reg_wr && reg_addr == 3) m_ien = reg_wdata[2:0];
        end
        #2;
        if (!rst_n) begin
            chk("R10 reset rdata", reg_rdata, 0);
            chk("R10 reset irq", irq, 0);
        end else begin
            chk("R1 tx avail", eng_tx_avail, txq.size() != 0);
            chk("R1 rx space", eng_rx_space, rxq.size() != 16);
            chk("R2 tx head", eng_tx_data, txq.size() ? txq[0] : 0);
            chk("R8 irq", irq, (m_stat & m_ien) != 0);
            case (reg_addr)
                3'd0: chk("R2 rx head", reg_rdata, rxq.size() ? rxq[0] : 0);
                3'd1: chk("R3 ctrl readback", reg_rdata, (m_rxt << 4) | (m_txc << 2));
                3'd2: begin
                    chk("R5 tx level flag", reg_rdata[0], m_stat & 1);
                    chk("R4 rx level flag", reg_rdata[1], (m_stat >> 1) & 1);
                    chk("R6 tx end flag", reg_rdata[2], (m_stat >> 2) & 1);
                    chk("R7 status byte", reg_rdata, m_stat);
                end
                3'd3: chk("R8 enable readback", reg_rdata, m_ien);
                3'd4: chk("R9 rx count", reg_rdata, rxq.size());
                3'd5: chk("R9 tx count", reg_rdata, txq.size());
                default: chk("R10 unused address", reg_rdata, 0);
            endcase
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(input bit wr, input bit rd, input logic [2:0] a, input logic [7:0] d,
                        input bit tp, input bit rp, input logic [7:0] rdat, input bit td);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
        eng_tx_pop = tp; eng_rx_push = rp; eng_rx_data = rdat; eng_tx_done = td;
    endtask

    task automatic idle(input logic [2:0] a, input int n);
        repeat (n) step(0, 0, a, 8'h00, 0, 0, 8'h00, 0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        step(1, 0, a, d, 0, 0, 8'h00, 0);
    endtask

    task automatic fill_tx(input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) wr(3'd0, seed + 8'(i * 7));
    endtask

    // Drain with a given threshold code after clearing status: R5
    task automatic drain_code(input logic [1:0] code);
        wr(3'd1, 8'(code) << 2);
        fill_tx(16, 8'h40);
        wr(3'd2, 8'h00);
        for (int i = 0; i < 17; i++) step(0, 0, 3'd2, 8'h00, 1, 0, 8'h00, 0);
        idle(3'd2, 2);
    endtask

    initial begin
        idle(3'd2, 2);
        idle(3'd1, 1);
        @(negedge clk) rst_n = 1'b1;
        idle(3'd2, 2);              // R10 status after reset
        idle(3'd5, 1);

        // R1: 18 writes, only 16 stored
        fill_tx(18, 8'h11);
        idle(3'd5, 2);
        // R1: full push together with engine pop
        step(1, 0, 3'd5, 8'hAA, 1, 0, 8'h00, 0);
        step(1, 0, 3'd5, 8'hBB, 1, 0, 8'h00, 0);
        idle(3'd5, 1);

        // R5 code 2 drain, then R2 order, and pops beyond empty
        wr(3'd1, 8'h08);
        wr(3'd2, 8'h00);
        for (int i = 0; i < 18; i++) step(0, 0, 3'd2, 8'h00, 1, 0, 8'h00, 0);
        idle(3'd2, 1);

        // R6: engine done with empty queue
        step(0, 0, 3'd2, 8'h00, 0, 0, 8'h00, 1);
        idle(3'd2, 2);
        // R7: keep bits 0 and 2, clear bit 1
        wr(3'd2, 8'h05);
        idle(3'd2, 1);
        // R7: clear all while tx level condition still holds
        wr(3'd2, 8'h00);
        idle(3'd2, 2);

        // R8: enables
        wr(3'd3, 8'h04);
        idle(3'd3, 2);
        wr(3'd3, 8'h01);
        idle(3'd3, 2);
        wr(3'd3, 8'h02);

        // R4: receive threshold 3 -> flag at 4 bytes; 17 pushes, one dropped
        wr(3'd1, 8'h30);
        wr(3'd2, 8'h00);
        for (int i = 0; i < 17; i++) step(0, 0, 3'd2, 8'h00, 0, 1, 8'(8'hC0 + i), 0);
        idle(3'd4, 2);
        // R1: full rx push with cpu pop in same cycle
        step(0, 1, 3'd0, 8'h00, 0, 1, 8'h77, 0);
        // R2: read back in order, past empty
        for (int i = 0; i < 18; i++) step(0, 1, 3'd0, 8'h00, 0, 0, 8'h00, 0);
        idle(3'd4, 1);

        // R3: independent flush of each queue
        fill_tx(5, 8'h21);
        for (int i = 0; i < 5; i++) step(0, 0, 3'd4, 8'h00, 0, 1, 8'(i + 1), 0);
        step(1, 0, 3'd1, 8'h32, 0, 1, 8'h99, 0);   // rx flush wins over push
        idle(3'd4, 1);
        idle(3'd5, 1);
        idle(3'd1, 1);
        step(1, 0, 3'd1, 8'h01, 1, 0, 8'h00, 0);   // tx flush wins over pop
        idle(3'd5, 2);

        // R5: remaining codes
        drain_code(2'd0);
        drain_code(2'd1);
        drain_code(2'd3);

        // R2: simultaneous engine push and cpu pop with data in both directions
        fill_tx(3, 8'h50);
        for (int i = 0; i < 3; i++) step(0, 0, 3'd0, 8'h00, 0, 1, 8'(8'h60 + i), 0);
        for (int i = 0; i < 4; i++) step(1, 1, 3'd0, 8'(8'h70 + i), 1, 1, 8'(8'h80 + i), 0);
        idle(3'd4, 2);
        idle(3'd7, 1);

        idle(3'd2, 2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule